// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in without any clock, producing a 16-bit sum and a carry-out. The operand is split into four slices of four bits. Each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Each slice folds its four bit terms into one slice generate and one slice propagate. A second lookahead unit of the same shape then computes the carry entering every slice directly from those slice terms and the carry-in, so no carry ripples from one slice to the next.

Inside a slice, the carries into its upper three bits come from the bit terms and the carry delivered to that slice by the second level. Each sum bit is the exclusive-or of the two operand bits and the carry into that bit. The slice generate and propagate terms are brought out as ports so that the hierarchical carry logic can be observed at the boundary. The block is meant to sit in a datapath as the adder of an arithmetic unit; subtraction, flags and pipelining are left to its surroundings.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + carry_in_i`, with all three read as unsigned numbers.
- R2: `carry_out_o` equals bit 16 of `a_i + b_i + carry_in_i`.
- R3: For slice k (k = 0..3, covering operand bits 4k to 4k+3), `grp_gen_o[k]` is 1 exactly when the two 4-bit slice values add to 16 or more with no carry-in.
- R4: `grp_prop_o[k]` is 1 exactly when every bit position of slice k has at least one operand bit set; consequently `grp_gen_o[k] | grp_prop_o[k]` is 1 exactly when the slice values plus one reach 16.
- R5: A carry crosses every slice boundary: when each bit position has exactly one operand bit set and `carry_in_i` is 1, `sum_o` is 0 and `carry_out_o` is 1.
- R6: With both operands zero, `sum_o` equals `carry_in_i` in bit 0 and zero elsewhere, and `carry_out_o` is 0.
- R7: The outputs are a combinational function of the inputs only: a new input pattern is reflected on all outputs within the same cycle in which it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_in_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_out_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 4 | Generate term of each 4-bit slice, slice 0 in bit 0 |
| grp_prop_o | output | 4 | Propagate term of each 4-bit slice, slice 0 in bit 0 |

## Verification
Each slice is driven through all 512 combinations of its own operand bits and the carry-in with the other slices held at zero, which catches a wrong product term in the expanded carry equations: a missing term drops a carry into one bit for a handful of inputs, and an extra one adds a spurious carry. Full-width patterns then aim at the slice boundaries, where a second-level unit that chained slices wrongly or fed a slice the carry meant for its neighbour would give a sum off by a power of sixteen or a wrong carry-out. The all-propagate chain with a carry-in and the zero-operand case isolate the carry-in path, and a propagate term built from exclusive-or instead of inclusive-or shows up on `grp_prop_o` whenever both operand bits of a position are set.

// File: rtl/lac_pkg.sv
package lac_pkg;
  // Width of one lookahead slice and number of slices in the adder.
  localparam int unsigned SLICE_BITS  = 4;
  localparam int unsigned SLICE_COUNT = 4;
  localparam int unsigned ADD_BITS    = SLICE_BITS * SLICE_COUNT;
endpackage

// File: rtl/lac_lookahead.sv
// Lookahead unit: from N generate/propagate pairs and a carry-in, forms
// the carries into positions 1..N-1 in expanded two-level form, plus the
// block generate and block propagate used by the next level up.
module lac_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-2:0] carry_o,
  output logic         blk_gen_o,
  output logic         blk_prop_o
);

  logic chain;
  logic term;
  logic acc;

  always_comb begin
    carry_o    = '0;
    blk_gen_o  = 1'b0;
    blk_prop_o = 1'b1;
    chain      = 1'b0;
    term       = 1'b0;
    acc        = 1'b0;
    // Carry into position k: the carry-in propagated through 0..k-1, or a
    // generate at j propagated through j+1..k-1.
    for (int k = 1; k < N; k++) begin
      chain = cin_i;
      for (int i = 0; i < k; i++) begin
        chain = chain & prop_i[i];
      end
      acc = chain;
      for (int j = 0; j < k; j++) begin
        term = gen_i[j];
        for (int i = j + 1; i < k; i++) begin
          term = term & prop_i[i];
        end
        acc = acc | term;
      end
      carry_o[k-1] = acc;
    end
    // Block generate: same expansion at position N without the carry-in.
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int i = j + 1; i < N; i++) begin
        term = term & prop_i[i];
      end
      acc = acc | term;
    end
    blk_gen_o = acc;
    for (int i = 0; i < N; i++) begin
      blk_prop_o = blk_prop_o & prop_i[i];
    end
  end

endmodule

// File: rtl/lac_slice.sv
// One slice of the adder: bit terms, internal carries from the slice's own
// incoming carry, sum bits, and the slice generate/propagate pair.
module lac_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         slice_gen_o,
  output logic         slice_prop_o
);

  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W-2:0] inner_carry;
  logic [W-1:0] carry_vec;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i | b_i;

  lac_lookahead #(.N(W)) u_inner (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin_i      (cin_i),
    .carry_o    (inner_carry),
    .blk_gen_o  (slice_gen_o),
    .blk_prop_o (slice_prop_o)
  );

  assign carry_vec = {inner_carry, cin_i};
  assign sum_o     = a_i ^ b_i ^ carry_vec;

endmodule

// File: rtl/lookahead_adder.sv
// Two-level carry-lookahead adder: slices feed a second lookahead unit that
// delivers every slice carry-in directly from slice terms and carry_in_i.
module lookahead_adder
  import lac_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_BITS,
  parameter int unsigned SLICE_N = SLICE_COUNT,
  localparam int unsigned WIDTH  = SLICE_W * SLICE_N
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               carry_in_i,
  output logic [WIDTH-1:0]   sum_o,
  output logic               carry_out_o,
  output logic [SLICE_N-1:0] grp_gen_o,
  output logic [SLICE_N-1:0] grp_prop_o
);

  logic [SLICE_N-1:0] slice_cin;
  logic [SLICE_N-2:0] upper_carry;
  logic               top_gen;
  logic               top_prop;

  lac_lookahead #(.N(SLICE_N)) u_upper (
    .gen_i      (grp_gen_o),
    .prop_i     (grp_prop_o),
    .cin_i      (carry_in_i),
    .carry_o    (upper_carry),
    .blk_gen_o  (top_gen),
    .blk_prop_o (top_prop)
  );

  assign slice_cin   = {upper_carry, carry_in_i};
  assign carry_out_o = top_gen | (top_prop & carry_in_i);

  for (genvar s = 0; s < SLICE_N; s++) begin : g_slice
    lac_slice #(.W(SLICE_W)) u_slice (
      .a_i          (a_i[s*SLICE_W +: SLICE_W]),
      .b_i          (b_i[s*SLICE_W +: SLICE_W]),
      .cin_i        (slice_cin[s]),
      .sum_o        (sum_o[s*SLICE_W +: SLICE_W]),
      .slice_gen_o  (grp_gen_o[s]),
      .slice_prop_o (grp_prop_o[s])
    );
  end

endmodule

// File: rtl/lookahead_adder_chk.sv
// Property checker for lookahead_adder, attached by bind below.
module lookahead_adder_chk #(
  parameter int unsigned SLICE_W = 4,
  parameter int unsigned SLICE_N = 4,
  localparam int unsigned WIDTH  = SLICE_W * SLICE_N
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               carry_in_i,
  input logic [WIDTH-1:0]   sum_o,
  input logic               carry_out_o,
  input logic [SLICE_N-1:0] grp_gen_o,
  input logic [SLICE_N-1:0] grp_prop_o
);

  logic [WIDTH:0]   total;
  logic [SLICE_W:0] pair_sum;

  always_comb begin
    total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_in_i};
    // R1
    sum_value_chk: assert (sum_o == total[WIDTH-1:0]);
    // R2
    carry_out_chk: assert (carry_out_o == total[WIDTH]);
    // R5
    full_chain_chk: assert (!((&(a_i ^ b_i)) && carry_in_i)
                            || (sum_o == '0 && carry_out_o));
    // R6
    zero_operand_chk: assert (!(a_i == '0 && b_i == '0)
                              || (sum_o == {{(WIDTH-1){1'b0}}, carry_in_i}
                                  && !carry_out_o));
    pair_sum = '0;
    for (int s = 0; s < SLICE_N; s++) begin
      pair_sum = {1'b0, a_i[s*SLICE_W +: SLICE_W]}
               + {1'b0, b_i[s*SLICE_W +: SLICE_W]};
      // R3
      slice_gen_chk: assert (grp_gen_o[s] == pair_sum[SLICE_W]);
      // R4
      slice_pass_chk: assert ((grp_gen_o[s] | grp_prop_o[s])
                              == ((pair_sum + 1'b1) > (SLICE_W+1)'((1 << SLICE_W) - 1)));
    end
  end

endmodule

bind lookahead_adder lookahead_adder_chk #(
  .SLICE_W (SLICE_W),
  .SLICE_N (SLICE_N)
) u_lookahead_adder_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .carry_in_i  (carry_in_i),
  .sum_o       (sum_o),
  .carry_out_o (carry_out_o),
  .grp_gen_o   (grp_gen_o),
  .grp_prop_o  (grp_prop_o)
);

// File: tb/test_lookahead_adder.sv
`timescale 1ns/1ps
module test_lookahead_adder;

  localparam int WIDTH = 16;
  localparam int SW    = 4;
  localparam int SN    = 4;

  logic             clk;
  logic [WIDTH-1:0] a_i;
  logic [WIDTH-1:0] b_i;
  logic             carry_in_i;
  logic [WIDTH-1:0] sum_o;
  logic             carry_out_o;
  logic [SN-1:0]    grp_gen_o;
  logic [SN-1:0]    grp_prop_o;

  int checks;
  int failures;
  bit finished;

  lookahead_adder i_lookahead_adder (
    .a_i         (a_i),
    .b_i         (b_i),
    .carry_in_i  (carry_in_i),
    .sum_o       (sum_o),
    .carry_out_o (carry_out_o),
    .grp_gen_o   (grp_gen_o),
    .grp_prop_o  (grp_prop_o)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Drive just after a rising edge; sample at the following falling edge.
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic cin);
    @(posedge clk);
    #1;
    a_i        = a;
    b_i        = b;
    carry_in_i = cin;
    @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%b expected=%b",
               tag, a_i, b_i, carry_in_i, act, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [WIDTH-1:0] act,
                            input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
               tag, a_i, b_i, carry_in_i, act, exp);
    end
  endtask

  // Full comparison of all outputs against plain arithmetic.
  task automatic check_all();
    logic [WIDTH:0] ref_total;
    logic [SW:0]    ps;
    logic [SW-1:0]  sa;
    logic [SW-1:0]  sb;
    ref_total = {1'b0, a_i} + {1'b0, b_i} + {16'd0, carry_in_i};
    check_word("R1 sum", sum_o, ref_total[WIDTH-1:0]);
    check_bit("R2 carry_out", carry_out_o, ref_total[WIDTH]);
    for (int s = 0; s < SN; s++) begin
      sa = a_i[s*SW +: SW];
      sb = b_i[s*SW +: SW];
      ps = {1'b0, sa} + {1'b0, sb};
      check_bit("R3 slice_gen", grp_gen_o[s], ps[SW]);
      check_bit("R4 slice_prop", grp_prop_o[s], &(sa | sb));
    end
  endtask

  task automatic t_idle_state();
    apply('0, '0, 1'b0);
    check_word("R6 idle sum", sum_o, '0);
    check_bit("R6 idle carry", carry_out_o, 1'b0);
    check_word("R3 idle gen", {12'd0, grp_gen_o}, '0);
    check_word("R4 idle prop", {12'd0, grp_prop_o}, '0);
  endtask

  task automatic t_slice_exhaustive();
    for (int s = 0; s < SN; s++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          for (int c = 0; c < 2; c++) begin
            apply(WIDTH'(x) << (s*SW), WIDTH'(y) << (s*SW), c[0]);
            check_all();
          end
        end
      end
    end
  endtask

  task automatic t_carry_in_only();
    apply('0, '0, 1'b1);
    check_word("R6 cin only sum", sum_o, 16'h0001);
    check_bit("R6 cin only carry", carry_out_o, 1'b0);
  endtask

  task automatic t_chain();
    apply(16'hFFFF, 16'h0000, 1'b1);
    check_word("R5 chain sum", sum_o, 16'h0000);
    check_bit("R5 chain carry", carry_out_o, 1'b1);
    apply(16'hA5C3, 16'h5A3C, 1'b1);
    check_word("R5 mixed chain sum", sum_o, 16'h0000);
    check_bit("R5 mixed chain carry", carry_out_o, 1'b1);
    check_word("R4 mixed chain prop", {12'd0, grp_prop_o}, 16'h000F);
    check_word("R3 mixed chain gen", {12'd0, grp_gen_o}, 16'h0000);
  endtask

  task automatic t_boundaries();
    apply(16'h000F, 16'h0001, 1'b0);
    check_word("R1 boundary0 sum", sum_o, 16'h0010);
    apply(16'h0FFF, 16'h0001, 1'b0);
    check_word("R1 boundary2 sum", sum_o, 16'h1000);
    apply(16'h0FF0, 16'h0010, 1'b0);
    check_word("R1 skip sum", sum_o, 16'h1000);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check_word("R1 max sum", sum_o, 16'hFFFF);
    check_bit("R2 max carry", carry_out_o, 1'b1);
    check_word("R3 max gen", {12'd0, grp_gen_o}, 16'h000F);
    apply(16'h8000, 16'h8000, 1'b0);
    check_word("R1 top sum", sum_o, 16'h0000);
    check_bit("R2 top carry", carry_out_o, 1'b1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 4000; n++) begin
      apply(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom));
      check_all();
    end
  endtask

  // R7: each new pattern is seen within the cycle it was applied.
  task automatic t_same_cycle();
    apply(16'h1234, 16'h4321, 1'b0);
    check_word("R7 same cycle sum A", sum_o, 16'h5555);
    apply(16'h7FFF, 16'h0001, 1'b0);
    check_word("R7 same cycle sum B", sum_o, 16'h8000);
    check_bit("R7 same cycle carry B", carry_out_o, 1'b0);
  endtask

  initial begin
    checks     = 0;
    failures   = 0;
    finished   = 1'b0;
    a_i        = '0;
    b_i        = '0;
    carry_in_i = 1'b0;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_carry_in_only();
    t_chain();
    t_boundaries();
    t_same_cycle();
    t_slice_exhaustive();
    t_random();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule